// File: doc/BRIEF.md
# Program Counter Sequencer with Write-Triggered Branching

This block owns the 12-bit program counter of a processor whose data path works four bits at a time. The counter is split into high, middle and low nibbles that appear to the data path as registers at fixed addresses. A fourth address, the call register, sits next to them. The block watches every register write. It decides whether that write is a plain store, a jump or a subroutine call. It also keeps a private return stack and carries out the return instruction.

The high and middle nibbles are staging registers. They are filled either one at a time through the write port or together by a two-nibble immediate load. A write to the low nibble jumps to the staged high and middle nibbles joined with the new low nibble. A write to the call register goes to the same kind of target and also pushes the address of the following instruction. A write only branches when the decoder raises the branch qualifier. The decoder raises it for register-to-register moves, immediate moves, increments and decrements. Any other instruction that writes these addresses is a plain store.

A return drives an immediate nibble to R0 through a one-cycle load strobe, then pops the stack into the counter. The stack pointer always names the next free entry. All control pins are plain level signals sampled on the rising clock edge. No stream flows through the block, so there is no valid/ready handshake.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset, `pc` is 0x000, `stack_level` is 0, `stack_err` is 0, `r0_we` is 0, and both staged nibbles are 0.
- R2: When only `step` is asserted, `pc` becomes `pc+1` on the next edge, and 0xFFF wraps to 0x000.
- R3: A write to the high-nibble address (default 0x0D) or the middle-nibble address (0x0E) only stages the nibble, whatever the qualifier. `imm_pc_en` stages `imm_pc_data[7:4]` as high and `imm_pc_data[3:0]` as middle, and it overrides a same-cycle port write to those addresses. Neither changes `pc` beyond what `step` does.
- R4: A qualified write (`wr_en` and `wr_branch_ok`) to the low-nibble address (0x0F) loads `pc` with {high, middle, `wr_data`} on the next edge. `step` in that cycle is ignored.
- R5: A qualified write to the call address (0x0C) loads `pc` with {high, middle, `wr_data`}. It pushes `pc+1` (modulo 4096), where `pc` is the current value, and raises `stack_level` by one.
- R6: A write to the low or call address without `wr_branch_ok` leaves `pc` following `step` only, and leaves the stack unchanged.
- R7: `ret_en` raises `r0_we` for exactly the next cycle with `r0_wdata` equal to `ret_imm`. When the stack is not empty, it lowers `stack_level` by one and loads `pc` with the most recently pushed address, so entries come back last-in first-out.
- R8: A qualified call while `stack_level` equals DEPTH (8) still loads `pc` with the target. It pushes nothing, leaves `stack_level` unchanged and sets `stack_err`.
- R9: `ret_en` with an empty stack still performs the R0 load. It sets `stack_err`, leaves `stack_level` at 0, and `pc` follows `step`.
- R10: `stack_err` stays at 1 once set, until reset.
- R11: Only one flow change happens per cycle, in this priority: return, then qualified low write, then qualified call write, then `step`. A staging write in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe from the data path |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 4 | Register write nibble |
| wr_branch_ok | input | 1 | Decoder qualifier: this write may branch |
| imm_pc_en | input | 1 | Two-nibble immediate load of the staged high and middle nibbles |
| imm_pc_data | input | 8 | {high, middle} for the immediate load |
| step | input | 1 | Advance `pc` by one instruction |
| ret_en | input | 1 | Execute return |
| ret_imm | input | 4 | Immediate nibble for R0 on return |
| pc | output | 12 | Current program counter |
| r0_we | output | 1 | One-cycle R0 load strobe after a return |
| r0_wdata | output | 4 | Nibble to load into R0 |
| stack_level | output | 4 | Stack pointer: the number of entries held |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions take it that `ret_en` and a qualified branch write may arrive in the same cycle and that the priority rule settles the conflict. They also take it that stimulus may hit the stack at both limits, and that the stack's read data is only used while the stack holds an entry. The stimulus sends every kind of write to the four mapped addresses and to an unrelated address, with the qualifier both set and clear. It includes same-cycle return and write conflicts, and it pushes nine calls in a row and pops nine times, so that both stack-error paths run on purpose. Random phases mix all of these, and a behavioural queue model tracks the expected state cycle by cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int NIB_W  = 4;
  localparam int PC_NIB = 3;
  localparam int PC_W   = NIB_W * PC_NIB;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_STEP = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } pcu_op_e;
endpackage

// File: rtl/pcu_write_decode.sv
module pcu_write_decode
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h0D,
  parameter logic [ADDR_W-1:0] MID_ADDR  = 8'h0E,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h0F,
  parameter logic [ADDR_W-1:0] CALL_ADDR = 8'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NIB_W-1:0]    wr_data,
  input  logic                wr_branch_ok,
  input  logic                imm_pc_en,
  input  logic [2*NIB_W-1:0]  imm_pc_data,
  input  logic                step,
  input  logic                ret_en,
  output pcu_op_e             op,
  output logic [PC_W-1:0]     target
);
  logic [NIB_W-1:0] stage_hi;
  logic [NIB_W-1:0] stage_mid;
  logic             qual_wr;
  logic             hit_lo;
  logic             hit_call;

  assign qual_wr  = wr_en && wr_branch_ok;
  assign hit_lo   = qual_wr && (wr_addr == LO_ADDR);
  assign hit_call = qual_wr && (wr_addr == CALL_ADDR);
  assign target   = {stage_hi, stage_mid, wr_data};

  always_comb begin
    op = OP_IDLE;
    if (ret_en)        op = OP_RET;
    else if (hit_lo)   op = OP_JUMP;
    else if (hit_call) op = OP_CALL;
    else if (step)     op = OP_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi  <= '0;
      stage_mid <= '0;
    end else begin
      if (wr_en && wr_addr == HI_ADDR)  stage_hi  <= wr_data;
      if (wr_en && wr_addr == MID_ADDR) stage_mid <= wr_data;
      if (imm_pc_en) begin
        stage_hi  <= imm_pc_data[2*NIB_W-1:NIB_W];
        stage_mid <= imm_pc_data[NIB_W-1:0];
      end
    end
  end

  // R3
  imm_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_pc_en |=> (stage_hi == $past(imm_pc_data[2*NIB_W-1:NIB_W]) &&
                   stage_mid == $past(imm_pc_data[NIB_W-1:0])));

  // R11
  ret_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en |-> (op == OP_RET));
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack
  import pcu_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SP_W   = $clog2(DEPTH + 1),
  localparam int SLOTS  = DEPTH * PC_NIB,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PC_W-1:0]  push_addr,
  input  logic             pop,
  output logic [PC_W-1:0]  pop_addr,
  output logic             empty,
  output logic [SP_W-1:0]  level,
  output logic             err
);
  logic [NIB_W-1:0]  mem [SLOTS];
  logic [SP_W-1:0]   sp;
  logic              full;
  logic [SLOT_W-1:0] wbase;
  logic [SLOT_W-1:0] rbase;

  assign full  = (sp == SP_W'(DEPTH));
  assign empty = (sp == '0);
  assign level = sp;
  assign wbase = SLOT_W'(sp) * SLOT_W'(PC_NIB);
  assign rbase = empty ? '0 : SLOT_W'(sp - 1'b1) * SLOT_W'(PC_NIB);

  // low nibble at base, middle at base+1, high at base+2
  always_ff @(posedge clk) begin
    if (push && !full) begin
      for (int k = 0; k < PC_NIB; k++)
        mem[wbase + SLOT_W'(k)] <= push_addr[k*NIB_W +: NIB_W];
    end
  end

  for (genvar g = 0; g < PC_NIB; g++) begin : g_rd
    assign pop_addr[g*NIB_W +: NIB_W] = mem[rbase + SLOT_W'(g)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      err <= 1'b0;
    end else begin
      if (push && !full)  sp <= sp + 1'b1;
      if (pop && !empty)  sp <= sp - 1'b1;
      if ((push && full) || (pop && empty)) err <= 1'b1;
    end
  end

  // R5
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (level == $past(level) + 1'b1));
  // R7
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty) |=> (level == $past(level) - 1'b1));
  // R8
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (level == $past(level) && err));
  // R9
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (level == '0 && err));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= SP_W'(DEPTH));
endmodule

// File: rtl/pcu_pc_seq.sv
module pcu_pc_seq
  import pcu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pcu_op_e          op,
  input  logic             step,
  input  logic [PC_W-1:0]  target,
  input  logic [PC_W-1:0]  pop_addr,
  input  logic             stack_empty,
  input  logic [NIB_W-1:0] ret_imm,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  next_seq,
  output logic             r0_we,
  output logic [NIB_W-1:0] r0_wdata
);
  assign next_seq = pc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      r0_we    <= 1'b0;
      r0_wdata <= '0;
    end else begin
      r0_we <= (op == OP_RET);
      if (op == OP_RET) r0_wdata <= ret_imm;
      unique case (op)
        OP_JUMP, OP_CALL: pc <= target;
        OP_STEP:          pc <= next_seq;
        OP_RET: begin
          if (!stack_empty) pc <= pop_addr;
          else if (step)    pc <= next_seq;
        end
        default: ;
      endcase
    end
  end

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (pc == $past(pc) + 1'b1));
  // R4
  jump_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP) |=> (pc == $past(target)));
  // R5
  call_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CALL) |=> (pc == $past(target)));
  // R7
  r0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET) |=> (r0_we && r0_wdata == $past(ret_imm)));
  // R7
  r0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_RET) |=> !r0_we);
  // R9
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET && stack_empty && !step) |=> $stable(pc));
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h0D,
  parameter logic [ADDR_W-1:0] MID_ADDR  = 8'h0E,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h0F,
  parameter logic [ADDR_W-1:0] CALL_ADDR = 8'h0C,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_data,
  input  logic              wr_branch_ok,
  input  logic              imm_pc_en,
  input  logic [7:0]        imm_pc_data,
  input  logic              step,
  input  logic              ret_en,
  input  logic [3:0]        ret_imm,
  output logic [11:0]       pc,
  output logic              r0_we,
  output logic [3:0]        r0_wdata,
  output logic [SP_W-1:0]   stack_level,
  output logic              stack_err
);
  pcu_op_e         op;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] pop_addr;
  logic [PC_W-1:0] next_seq;
  logic            stack_empty;

  pcu_write_decode #(
    .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .MID_ADDR(MID_ADDR),
    .LO_ADDR(LO_ADDR), .CALL_ADDR(CALL_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_branch_ok(wr_branch_ok), .imm_pc_en(imm_pc_en),
    .imm_pc_data(imm_pc_data), .step(step), .ret_en(ret_en),
    .op(op), .target(target)
  );

  pcu_ret_stack #(.DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(op == OP_CALL), .push_addr(next_seq),
    .pop(op == OP_RET), .pop_addr(pop_addr), .empty(stack_empty),
    .level(stack_level), .err(stack_err)
  );

  pcu_pc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .step(step), .target(target),
    .pop_addr(pop_addr), .stack_empty(stack_empty), .ret_imm(ret_imm),
    .pc(pc), .next_seq(next_seq), .r0_we(r0_we), .r0_wdata(r0_wdata)
  );
endmodule

// File: tb/tb_pc_branch_unit.sv
module tb_pc_branch_unit;
  localparam int DEPTH = 8;
  localparam logic [7:0] A_HI = 8'h0D, A_MID = 8'h0E, A_LO = 8'h0F, A_CALL = 8'h0C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_branch_ok = 0, imm_pc_en = 0, step = 0, ret_en = 0;
  logic [7:0] wr_addr = 0, imm_pc_data = 0;
  logic [3:0] wr_data = 0, ret_imm = 0;
  logic [11:0] pc;
  logic r0_we, stack_err;
  logic [3:0] r0_wdata;
  logic [3:0] stack_level;

  int n_chk = 0, n_fail = 0;

  // reference state
  int m_pc = 0, m_hi = 0, m_mid = 0, m_err = 0, m_r0we = 0, m_r0d = 0;
  int m_stk[$];
  string tag = "R1";
  string err_tag = "R1";

  always #4 clk = ~clk;

  pc_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_branch_ok(wr_branch_ok), .imm_pc_en(imm_pc_en), .imm_pc_data(imm_pc_data),
    .step(step), .ret_en(ret_en), .ret_imm(ret_imm), .pc(pc), .r0_we(r0_we),
    .r0_wdata(r0_wdata), .stack_level(stack_level), .stack_err(stack_err)
  );

  task automatic chk(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tag, "pc", int'(pc), m_pc);
    chk(tag, "stack_level", int'(stack_level), m_stk.size());
    chk(err_tag, "stack_err", int'(stack_err), m_err);
    chk(tag, "r0_we", int'(r0_we), m_r0we);
    if (m_r0we != 0) chk("R7", "r0_wdata", int'(r0_wdata), m_r0d);
  endtask

  function automatic void model();
    bit q = wr_en && wr_branch_ok;
    int tgt = (m_hi << 8) | (m_mid << 4) | int'(wr_data);
    int was_err = m_err;
    m_r0we = 0;
    tag = "R2";
    if (ret_en) begin
      m_r0we = 1; m_r0d = int'(ret_imm);
      tag = (q && (wr_addr == A_LO || wr_addr == A_CALL)) ? "R11" : "R7";
      if (m_stk.size() == 0) begin
        m_err = 1; tag = "R9";
        if (step) m_pc = (m_pc + 1) % 4096;
      end else m_pc = m_stk.pop_back();
    end else if (q && wr_addr == A_LO) begin
      m_pc = tgt; tag = "R4";
    end else if (q && wr_addr == A_CALL) begin
      tag = "R5";
      if (m_stk.size() == DEPTH) begin m_err = 1; tag = "R8"; end
      else m_stk.push_back((m_pc + 1) % 4096);
      m_pc = tgt;
    end else begin
      if (wr_en && (wr_addr == A_LO || wr_addr == A_CALL)) tag = "R6";
      else if (wr_en && (wr_addr == A_HI || wr_addr == A_MID)) tag = "R3";
      else if (imm_pc_en) tag = "R3";
      if (step) m_pc = (m_pc + 1) % 4096;
    end
    if (wr_en && wr_addr == A_HI)  m_hi  = int'(wr_data);
    if (wr_en && wr_addr == A_MID) m_mid = int'(wr_data);
    if (imm_pc_en) begin m_hi = int'(imm_pc_data[7:4]); m_mid = int'(imm_pc_data[3:0]); end
    err_tag = (was_err != 0) ? "R10" : tag;
  endfunction

  task automatic cyc(bit we, logic [7:0] a, logic [3:0] d, bit ok,
                     bit ie, logic [7:0] id, bit st, bit rt, logic [3:0] ri);
    wr_en = we; wr_addr = a; wr_data = d; wr_branch_ok = ok;
    imm_pc_en = ie; imm_pc_data = id; step = st; ret_en = rt; ret_imm = ri;
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_step();
    cyc(0, 8'h20, 0, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pc", int'(pc), 0);
    chk("R1", "stack_level", int'(stack_level), 0);
    chk("R1", "stack_err", int'(stack_err), 0);
    chk("R1", "r0_we", int'(r0_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 staged nibbles are zero: a jump lands at 0x005
    cyc(1, A_LO, 4'h5, 1, 0, 0, 0, 0, 0);
    chk("R1", "pc_after_jump", int'(pc), 12'h005);
    // R3 staging through the immediate pair, then R4 jump to 0xFFE
    cyc(0, 8'h20, 0, 0, 1, 8'hFF, 1, 0, 0);
    cyc(1, A_LO, 4'hE, 1, 0, 0, 1, 0, 0);
    chk("R4", "pc_jump", int'(pc), 12'hFFE);
    // R2 wrap
    idle_step(); idle_step();
    chk("R2", "pc_wrap", int'(pc), 12'h000);
    // R6 unqualified low and call writes
    cyc(1, A_LO, 4'h3, 0, 0, 0, 1, 0, 0);
    cyc(1, A_CALL, 4'h3, 0, 0, 0, 0, 0, 0);
    // R3 port staging then R5 calls until overflow (R8)
    cyc(1, A_HI, 4'hA, 0, 0, 0, 1, 0, 0);
    cyc(1, A_MID, 4'h5, 1, 0, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH + 1; i++) cyc(1, A_CALL, 4'(i), 1, 0, 0, 1, 0, 0);
    chk("R8", "level_full", int'(stack_level), DEPTH);
    chk("R8", "err_set", int'(stack_err), 1);
    // R7 returns, then R9 underflow
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 8'h20, 0, 0, 0, 0, 1, 1, 4'(i + 3));
    chk("R9", "level_empty", int'(stack_level), 0);
    // R11 conflicts
    cyc(1, A_CALL, 4'h1, 1, 0, 0, 1, 0, 0);
    cyc(1, A_LO, 4'h9, 1, 0, 0, 1, 1, 4'h6);
    cyc(1, A_HI, 4'h2, 1, 0, 0, 0, 1, 4'h1);
    // random mix under reset again for fresh stack error
    rst_n = 1'b0;
    m_pc = 0; m_hi = 0; m_mid = 0; m_err = 0; m_r0we = 0; m_stk.delete();
    tag = "R1"; err_tag = "R1";
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] adr;
      int sel = $urandom_range(0, 4);
      adr = (sel == 0) ? A_HI : (sel == 1) ? A_MID : (sel == 2) ? A_LO :
            (sel == 3) ? A_CALL : 8'h21;
      cyc($urandom_range(0, 99) < 40, adr, 4'($urandom), $urandom_range(0, 1) == 1,
          $urandom_range(0, 9) == 0, 8'($urandom), $urandom_range(0, 3) != 0,
          $urandom_range(0, 99) < 12, 4'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule